// File: doc/BRIEF.md
# Presettable BCD Decade Counter

A four-bit synchronous counter that steps through the decimal digits 0 to 9 in 8421 binary-coded decimal on each rising clock edge, wrapping from 9 back to 0. It can be preset from a four-bit data input, held, or cleared. Two active-high count enables gate counting. One is a plain enable. The other, the chain enable, also qualifies the terminal-count flag, so that several digits can be cascaded into one synchronous multi-digit counter. In a cascade, each digit's terminal count feeds the chain enable of the next digit, and a shared enable drives every plain enable.

The clear input is active low. A parameter selects whether it acts at once, independent of the clock, or on the next rising edge. On each edge the block takes exactly one action, in strict precedence: clear, then preset, then count, then hold. The six codes that are not decimal digits (10 to 15) can be entered by presetting. While counting, each of them leads back into the decimal sequence within two counting edges.

Top module: `decade_preset_counter`

## Requirements
- R1: With ASYNC_RESET=1, rst_n low forces q to 0 at once, without a clock edge, and q stays 0 on every edge while rst_n is low, even with load_n low.
- R2: With rst_n and load_n high and both count enables high, a rising edge moves q from n to n+1 for n in 0..8, and from 9 to 0.
- R3: With ASYNC_RESET=0, rst_n low leaves q unchanged until the next rising edge and then sets q to 0, overriding both load and count.
- R4: With rst_n high and load_n low, a rising edge copies data_in into q, whatever the two count enables are.
- R5: With rst_n and load_n high, q keeps its value across a rising edge when cnt_en_par or cnt_en_chain is low.
- R6: tc is combinational and equals q[0] AND q[3] AND cnt_en_chain. It does not depend on cnt_en_par.
- R7: When counting from a non-decimal code, the successors are 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15 and 15 to 2, so that any code is back in 0..9 after at most two counting edges.
- R8: Two counters chained with tc of the low digit driving cnt_en_chain of the high digit, and a shared cnt_en_par, count 00 to 99 in decimal and wrap to 00. The high digit's tc is 1 at 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Active-low clear (immediate or on the edge, per ASYNC_RESET) |
| load_n | input | 1 | Active-low preset enable |
| data_in | input | 4 | Preset value |
| cnt_en_par | input | 1 | Plain count enable, active high |
| cnt_en_chain | input | 1 | Chain count enable, active high; also qualifies tc |
| q | output | 4 | Counter value |
| tc | output | 1 | Terminal-count flag |

## Verification
The clocked properties assume that load_n, data_in and both enables are settled around each rising edge. They also assume that rst_n is released away from an edge, so that the first edge after release sees a clean, defined state. The stimulus changes every data and control input two nanoseconds after a rising edge. The immediate-clear case lowers rst_n mid-cycle and checks q before the next edge. Non-decimal codes reach the counter only by presetting, which is how the stimulus covers every illegal successor and the tc decode on codes 11, 13 and 15.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

   localparam int DIGIT_W    = 4;
   localparam int LAST_DIGIT = 9;

   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_COUNT = 2'd1,
      MODE_LOAD  = 2'd2,
      MODE_CLEAR = 2'd3
   } dcnt_mode_e;

   // Successor of a code while counting; non-decimal codes rejoin 0..9 within two steps.
   function automatic logic [DIGIT_W-1:0] bcd_successor(input logic [DIGIT_W-1:0] cur);
      logic [DIGIT_W-1:0] nxt;
      if (cur == DIGIT_W'(LAST_DIGIT))
         nxt = '0;
      else if (cur < DIGIT_W'(LAST_DIGIT))
         nxt = cur + DIGIT_W'(1);
      else if (!cur[0])
         nxt = cur + DIGIT_W'(1);        // 10->11, 12->13, 14->15
      else begin
         case (cur)
            DIGIT_W'(11): nxt = DIGIT_W'(6);
            DIGIT_W'(13): nxt = DIGIT_W'(4);
            default:      nxt = DIGIT_W'(2); // 15
         endcase
      end
      return nxt;
   endfunction

endpackage

// File: rtl/dcnt_mode_sel.sv
module dcnt_mode_sel
   import dcnt_pkg::*;
(
   input  logic       rst_n,
   input  logic       load_n,
   input  logic       en_par,
   input  logic       en_chain,
   output dcnt_mode_e mode
);

   // Strict precedence: clear, preset, count, hold.
   always_comb begin
      if (!rst_n)
         mode = MODE_CLEAR;
      else if (!load_n)
         mode = MODE_LOAD;
      else if (en_par && en_chain)
         mode = MODE_COUNT;
      else
         mode = MODE_HOLD;
   end

endmodule

// File: rtl/dcnt_next_state.sv
module dcnt_next_state
   import dcnt_pkg::*;
(
   input  dcnt_mode_e         mode,
   input  logic [DIGIT_W-1:0] cur,
   input  logic [DIGIT_W-1:0] preset,
   output logic [DIGIT_W-1:0] nxt
);

   always_comb begin
      unique case (mode)
         MODE_CLEAR: nxt = '0;
         MODE_LOAD:  nxt = preset;
         MODE_COUNT: nxt = bcd_successor(cur);
         default:    nxt = cur;
      endcase
   end

endmodule

// File: rtl/dcnt_state_reg.sv
module dcnt_state_reg #(
   parameter int ASYNC_RESET = 1,
   parameter int W           = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (ASYNC_RESET != 0) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else
               q <= d;
         end
      end else begin : g_sync
         // Clear arrives through the next-state path.
         always_ff @(posedge clk) begin
            q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/dcnt_tc_decode.sv
module dcnt_tc_decode
   import dcnt_pkg::*;
(
   input  logic [DIGIT_W-1:0] cur,
   input  logic               en_chain,
   output logic               tc
);

   // Only bits 0 and 3 are decoded; 9 is the sole decimal code with both set.
   assign tc = cur[0] & cur[DIGIT_W-1] & en_chain;

endmodule

// File: rtl/decade_preset_counter.sv
module decade_preset_counter
   import dcnt_pkg::*;
#(
   parameter int ASYNC_RESET = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_n,
   input  logic [DIGIT_W-1:0] data_in,
   input  logic               cnt_en_par,
   input  logic               cnt_en_chain,
   output logic [DIGIT_W-1:0] q,
   output logic               tc
);

   generate
      if (ASYNC_RESET != 0 && ASYNC_RESET != 1) begin : g_bad_param
         $error("decade_preset_counter: ASYNC_RESET must be 0 or 1");
      end
      if (DIGIT_W != 4) begin : g_bad_width
         $error("decade_preset_counter: BCD digit must be 4 bits");
      end
   endgenerate

   dcnt_mode_e         mode;
   logic [DIGIT_W-1:0] state_q;
   logic [DIGIT_W-1:0] state_d;

   dcnt_mode_sel u_mode (
      .rst_n    (rst_n),
      .load_n   (load_n),
      .en_par   (cnt_en_par),
      .en_chain (cnt_en_chain),
      .mode     (mode)
   );

   dcnt_next_state u_next (
      .mode   (mode),
      .cur    (state_q),
      .preset (data_in),
      .nxt    (state_d)
   );

   dcnt_state_reg #(
      .ASYNC_RESET (ASYNC_RESET),
      .W           (DIGIT_W)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (state_d),
      .q     (state_q)
   );

   dcnt_tc_decode u_tc (
      .cur      (state_q),
      .en_chain (cnt_en_chain),
      .tc       (tc)
   );

   assign q = state_q;

endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
   parameter int ASYNC_RESET = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       load_n,
   input logic [3:0] data_in,
   input logic       cnt_en_par,
   input logic       cnt_en_chain,
   input logic [3:0] q,
   input logic       tc
);

   generate
      if (ASYNC_RESET != 0) begin : g_async_chk
         p_async_clear_r1: assert property (@(posedge clk) !rst_n |-> q == 4'd0);
      end
   endgenerate

   // Clear at an edge gives 0 at the next edge in both variants (R1, R3).
   p_sync_clear_r3: assert property (@(posedge clk) !rst_n |=> q == 4'd0);

   p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en_par && cnt_en_chain && q < 4'd9) |=> q == $past(q) + 4'd1);

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en_par && cnt_en_chain && q == 4'd9) |=> q == 4'd0);

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> q == $past(data_in));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(cnt_en_par && cnt_en_chain)) |=> $stable(q));

   p_tc_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tc == (q[0] && q[3] && cnt_en_chain));

   p_odd_illegal_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en_par && cnt_en_chain && q > 4'd9 && q[0]) |=> q <= 4'd9);

endmodule

bind decade_preset_counter dcnt_checker #(.ASYNC_RESET(ASYNC_RESET)) u_dcnt_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .load_n       (load_n),
   .data_in      (data_in),
   .cnt_en_par   (cnt_en_par),
   .cnt_en_chain (cnt_en_chain),
   .q            (q),
   .tc           (tc)
);

// File: tb/decade_preset_counter_bench.sv
module decade_preset_counter_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int n_checks = 0;
   int n_errors = 0;

   // Main instance (immediate clear)
   logic       a_rst_n = 1'b0, a_load_n = 1'b1, a_ep = 1'b0, a_et = 1'b0;
   logic [3:0] a_d = 4'd0;
   logic [3:0] a_q;
   logic       a_tc;

   decade_preset_counter #(.ASYNC_RESET(1)) u_decade_preset_counter (
      .clk(clk), .rst_n(a_rst_n), .load_n(a_load_n), .data_in(a_d),
      .cnt_en_par(a_ep), .cnt_en_chain(a_et), .q(a_q), .tc(a_tc));

   // Edge-clear instance
   logic       s_rst_n = 1'b0, s_load_n = 1'b1, s_ep = 1'b0, s_et = 1'b0;
   logic [3:0] s_d = 4'd0;
   logic [3:0] s_q;
   logic       s_tc;

   decade_preset_counter #(.ASYNC_RESET(0)) u_decade_preset_counter_sync (
      .clk(clk), .rst_n(s_rst_n), .load_n(s_load_n), .data_in(s_d),
      .cnt_en_par(s_ep), .cnt_en_chain(s_et), .q(s_q), .tc(s_tc));

   // Two-digit cascade
   logic       c_rst_n = 1'b0, c_en = 1'b0;
   logic [3:0] c_lo_q, c_hi_q;
   logic       c_lo_tc, c_hi_tc;

   decade_preset_counter #(.ASYNC_RESET(1)) u_decade_preset_counter_lo (
      .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .data_in(4'd0),
      .cnt_en_par(c_en), .cnt_en_chain(1'b1), .q(c_lo_q), .tc(c_lo_tc));

   decade_preset_counter #(.ASYNC_RESET(1)) u_decade_preset_counter_hi (
      .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .data_in(4'd0),
      .cnt_en_par(c_en), .cnt_en_chain(c_lo_tc), .q(c_hi_q), .tc(c_hi_tc));

   // Vector: {rst_n, load_n, d[3:0], ep, et, exp_q[3:0], exp_tc}
   localparam int NV = 19;
   localparam logic [12:0] VEC [NV] = '{
      {1'b1, 1'b0, 4'd7,  1'b0, 1'b0, 4'd7,  1'b0}, // R4 load, enables low
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd8,  1'b0}, // R2
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd9,  1'b1}, // R2 R6
      {1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd9,  1'b1}, // R5 R6 tc ignores ep
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 4'd9,  1'b0}, // R5 R6
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0}, // R2 wrap
      {1'b1, 1'b0, 4'd12, 1'b1, 1'b1, 4'd12, 1'b0}, // R4 load beats count
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd13, 1'b1}, // R7 R6
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd4,  1'b0}, // R7
      {1'b1, 1'b0, 4'd10, 1'b0, 1'b1, 4'd10, 1'b0}, // R4
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd11, 1'b1}, // R7 R6
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd6,  1'b0}, // R7
      {1'b1, 1'b0, 4'd14, 1'b1, 1'b0, 4'd14, 1'b0}, // R4
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd15, 1'b1}, // R7 R6
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd2,  1'b0}, // R7
      {1'b1, 1'b0, 4'd15, 1'b0, 1'b0, 4'd15, 1'b0}, // R4 R6
      {1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd15, 1'b1}, // R5 R6
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd2,  1'b0}, // R7
      {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd3,  1'b0}  // R2
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      tick();
      tick();
      a_rst_n = 1'b1; s_rst_n = 1'b1; c_rst_n = 1'b1;
      #1;
      check(a_q == 4'd0, "R1 reset q", a_q, 0);
      check(a_tc == 1'b0, "R1 reset tc", a_tc, 0);
      check(s_q == 4'd0, "R3 reset q", s_q, 0);

      // Vector table on the main instance
      for (int i = 0; i < NV; i++) begin
         a_rst_n  = VEC[i][12];
         a_load_n = VEC[i][11];
         a_d      = VEC[i][10:7];
         a_ep     = VEC[i][6];
         a_et     = VEC[i][5];
         tick();
         check(a_q == VEC[i][4:1], $sformatf("R2/R4/R5/R7 vec %0d q", i), a_q, VEC[i][4:1]);
         check(a_tc == VEC[i][0], $sformatf("R6 vec %0d tc", i), a_tc, VEC[i][0]);
      end

      // R1: immediate clear between edges, and it beats load
      a_load_n = 1'b0; a_d = 4'd5; a_ep = 1'b1; a_et = 1'b1;
      tick();
      check(a_q == 4'd5, "R4 preload", a_q, 5);
      a_rst_n = 1'b0;
      #1;
      check(a_q == 4'd0, "R1 immediate clear", a_q, 0);
      a_d = 4'd3;
      tick();
      check(a_q == 4'd0, "R1 clear beats load", a_q, 0);
      a_rst_n = 1'b1; a_load_n = 1'b1;
      tick();
      check(a_q == 4'd1, "R2 count after release", a_q, 1);

      // R3: edge clear waits for the edge and beats load and count
      s_load_n = 1'b0; s_d = 4'd5; s_ep = 1'b1; s_et = 1'b1;
      tick();
      check(s_q == 4'd5, "R4 sync preload", s_q, 5);
      s_rst_n = 1'b0; s_d = 4'd8;
      #1;
      check(s_q == 4'd5, "R3 no clear before edge", s_q, 5);
      tick();
      check(s_q == 4'd0, "R3 clear on edge", s_q, 0);
      s_rst_n = 1'b1; s_load_n = 1'b1;
      tick();
      check(s_q == 4'd1, "R3 count after release", s_q, 1);

      // R8: cascade 00..99 and wrap
      c_en = 1'b1;
      for (int k = 1; k <= 100; k++) begin
         tick();
         check(c_lo_q == 4'(k % 10) && c_hi_q == 4'((k / 10) % 10), "R8 cascade",
               int'(c_hi_q) * 10 + int'(c_lo_q), k % 100);
         if (k == 99)
            check(c_hi_tc == 1'b1, "R8 hi tc at 99", c_hi_tc, 1);
      end
      check(c_hi_tc == 1'b0, "R8 hi tc after wrap", c_hi_tc, 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule